// File: doc/BRIEF.md
# Parallel NOR Flash Host Bus Controller

This block lets a synchronous core reach an asynchronous parallel NOR flash module built from four byte-wide dies. The dies share a 17-bit address and one output enable. Each die has its own chip enable and write enable and owns one byte of the 32-bit data bus. The core issues one request at a time over a valid/ready handshake. The controller then sequences the flash pins so that every setup, pulse, hold and recovery minimum of the chosen speed grade is met. These minimums are given in nanoseconds and converted to whole clock cycles, rounded up.

Three request kinds exist: a plain write, a plain read, and a polling read. A plain write drives one byte into each selected lane, which is how command bytes and program data reach the dies. A plain read returns the bytes of the selected lanes. A polling read watches the lanes after a program or erase command has been issued. It reads the same address repeatedly until the busy-toggle status bit (bit 6 of each selected byte) holds its value across two reads in a row. If a cycle budget runs out first, it reports a timeout. The dies start in read mode, so the first request may be a read.

Top module: `pflash_host_ctrl`

## Requirements
- R1: While reset is asserted and whenever `req_ready` is high, every chip enable, every write enable and the output enable are high (inactive), and `fl_dq_oe` is 0.
- R2: A write with lane mask M pulls the write enable low only on lanes whose bit in M is 1 (bit i selects lane i, data bits 8i+7..8i). The pulse lasts max(ceil(tWP/Tclk), ceil(tDS/Tclk)) cycles: 2 cycles with a 20 ns clock. The output enable stays high for the whole write.
- R3: While any chip enable stays low across consecutive cycles, `fl_addr` does not change. While `fl_dq_oe` stays high, `fl_dq_o` does not change. Each write enable pulse is enclosed by its lane's chip enable, so address and data stay valid across both latching edges.
- R4: A write occupies a setup cycle, the pulse, and a recovery time long enough for write enable high time, address hold and total cycle time. With a 20 ns clock, `done` rises on the 4th rising edge after the accept edge.
- R5: A read holds the output enable low for max(ceil(tACC/Tclk)-1, ceil(tOE/Tclk)) cycles, which is 3 with a 20 ns clock. It then returns the captured bus in `done_rdata`, with bytes of unselected lanes forced to zero. With a 20 ns clock, `done` rises on the 5th edge after the accept edge.
- R6: `fl_dq_oe` is never high while the output enable is low. It is low in the cycle before every falling edge of the output enable.
- R7: `done` is a single-cycle pulse. `req_ready` is low from the cycle after an accept until `done` is pulsed. `done_timeout` is high only together with `done`.
- R8: A request with `req_poll`=1 is a read regardless of `req_write`. It repeats reads of 5 cycles each (20 ns clock) back to back. It completes with `done_timeout`=0 at the first read whose bit 6 of every selected lane equals the same bits of the previous read. `done_rdata` then holds that last read.
- R9: At the end of each polling read without a match, if the cycles spent on the request so far (5 per read with a 20 ns clock) are at least `poll_limit`, the request completes with `done_timeout`=1. A first read never matches.
- R10: A write enable is low only while the same lane's chip enable is low and the output enable is high.
- R11: Lanes whose mask bit is 0 in a write keep their stored byte, as seen by a later full-width read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller idle, request accepted when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_poll | input | 1 | 1 = polling read |
| req_lanes | input | 4 | Byte-lane mask, bit i = lane i |
| req_addr | input | 17 | Flash address |
| req_wdata | input | 32 | Write data, lane i in bits 8i+7..8i |
| poll_limit | input | 20 | Cycle budget for polling reads |
| done | output | 1 | Completion pulse |
| done_rdata | output | 32 | Read data, valid with done |
| done_timeout | output | 1 | Polling timed out, valid with done |
| fl_addr | output | 17 | Flash address pins |
| fl_ce_n | output | 4 | Per-lane chip enables, active low |
| fl_we_n | output | 4 | Per-lane write enables, active low |
| fl_oe_n | output | 1 | Shared output enable, active low |
| fl_dq_o | output | 32 | Data driven to flash |
| fl_dq_oe | output | 1 | Data bus drive enable |
| fl_dq_i | input | 32 | Data returned from flash |

## Verification
The bench builds the controller with a 20 ns clock. At that clock a write's `done` is due 4 edges after the accept edge, a plain read's 5 edges after, and a polling read's 5 edges per read performed. The bench counts falling clock edges from the accept edge to the cycle `done` is seen, so each latency is compared as an exact number. Pulse widths and lane selection come from a flash model that counts low runs and rising edges of the strobes at falling clock edges, where no pin is changing. The expected number of polling reads is worked out in the bench from the toggle sequence it arms in the model.

// File: rtl/pflash_host_ctrl.sv
module pflash_host_ctrl #(
  parameter int CLK_NS   = 10,
  parameter int T_WC_NS  = 70,
  parameter int T_WP_NS  = 35,
  parameter int T_WPH_NS = 20,
  parameter int T_AH_NS  = 45,
  parameter int T_DS_NS  = 30,
  parameter int T_ACC_NS = 70,
  parameter int T_OE_NS  = 35,
  parameter int T_DF_NS  = 20,
  parameter int AW       = 17,
  parameter int LANES    = 4,
  parameter int PCW      = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_poll,
  input  logic [LANES-1:0]  req_lanes,
  input  logic [AW-1:0]     req_addr,
  input  logic [8*LANES-1:0] req_wdata,
  input  logic [PCW-1:0]    poll_limit,
  output logic              done,
  output logic [8*LANES-1:0] done_rdata,
  output logic              done_timeout,
  output logic [AW-1:0]     fl_addr,
  output logic [LANES-1:0]  fl_ce_n,
  output logic [LANES-1:0]  fl_we_n,
  output logic              fl_oe_n,
  output logic [8*LANES-1:0] fl_dq_o,
  output logic              fl_dq_oe,
  input  logic [8*LANES-1:0] fl_dq_i
);

  function automatic int cyc(int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int DW     = 8 * LANES;
  localparam int TW     = 16;
  localparam int WPUL_C = imax(imax(cyc(T_WP_NS), cyc(T_DS_NS)), 1);
  localparam int WREC_C = imax(imax(cyc(T_WPH_NS), cyc(T_AH_NS) - WPUL_C),
                               imax(cyc(T_WC_NS) - 1 - WPUL_C, 1));
  localparam int ROE_C  = imax(imax(cyc(T_ACC_NS) - 1, cyc(T_OE_NS)), 1);
  localparam int RREL_C = imax(cyc(T_DF_NS), 1);

  typedef enum logic [2:0] {
    S_IDLE, S_WSET, S_WPUL, S_WREC, S_RADR, S_ROE, S_RREL
  } st_t;

  st_t              st;
  logic [TW-1:0]    tmr;
  logic [AW-1:0]    a_q;
  logic [LANES-1:0] lane_q;
  logic [DW-1:0]    wd_q, rd_q, prev_q, lmask, smask;
  logic             poll_q, have_prev;
  logic [PCW-1:0]   pcnt;
  logic             match, over;

  for (genvar g = 0; g < LANES; g++) begin : g_mask
    assign lmask[8*g +: 8] = {8{lane_q[g]}};
    assign smask[8*g +: 8] = {1'b0, lane_q[g], 6'b0};
  end

  assign req_ready = (st == S_IDLE);
  assign fl_addr   = a_q;
  assign fl_dq_o   = wd_q;
  assign fl_dq_oe  = (st == S_WSET) || (st == S_WPUL) || (st == S_WREC);
  assign fl_ce_n   = (fl_dq_oe || st == S_RADR || st == S_ROE) ? ~lane_q : '1;
  assign fl_we_n   = (st == S_WPUL) ? ~lane_q : '1;
  assign fl_oe_n   = (st != S_ROE);
  assign match     = have_prev && (((rd_q ^ prev_q) & smask) == '0);
  assign over      = ({1'b0, pcnt} + 1'b1) >= {1'b0, poll_limit};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      tmr          <= '0;
      a_q          <= '0;
      lane_q       <= '0;
      wd_q         <= '0;
      rd_q         <= '0;
      prev_q       <= '0;
      poll_q       <= 1'b0;
      have_prev    <= 1'b0;
      pcnt         <= '0;
      done         <= 1'b0;
      done_rdata   <= '0;
      done_timeout <= 1'b0;
    end else begin
      done         <= 1'b0;
      done_timeout <= 1'b0;
      if (st != S_IDLE && pcnt != '1) pcnt <= pcnt + 1'b1;
      case (st)
        S_IDLE: if (req_valid) begin
          a_q       <= req_addr;
          lane_q    <= req_lanes;
          wd_q      <= req_wdata;
          poll_q    <= req_poll;
          have_prev <= 1'b0;
          pcnt      <= '0;
          st        <= (req_write && !req_poll) ? S_WSET : S_RADR;
        end
        S_WSET: begin
          st  <= S_WPUL;
          tmr <= TW'(WPUL_C - 1);
        end
        S_WPUL:
          if (tmr == '0) begin
            st  <= S_WREC;
            tmr <= TW'(WREC_C - 1);
          end else tmr <= tmr - 1'b1;
        S_WREC:
          if (tmr == '0) begin
            st         <= S_IDLE;
            done       <= 1'b1;
            done_rdata <= '0;
          end else tmr <= tmr - 1'b1;
        S_RADR: begin
          st  <= S_ROE;
          tmr <= TW'(ROE_C - 1);
        end
        S_ROE:
          if (tmr == '0) begin
            rd_q <= fl_dq_i & lmask;
            st   <= S_RREL;
            tmr  <= TW'(RREL_C - 1);
          end else tmr <= tmr - 1'b1;
        S_RREL:
          if (tmr != '0) tmr <= tmr - 1'b1;
          else if (!poll_q || match || over) begin
            st           <= S_IDLE;
            done         <= 1'b1;
            done_rdata   <= rd_q;
            done_timeout <= poll_q && !match;
          end else begin
            prev_q    <= rd_q;
            have_prev <= 1'b1;
            st        <= S_RADR;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pflash_host_ctrl_chk.sv
module pflash_host_ctrl_chk #(
  parameter int WPUL  = 4,
  parameter int AW    = 17,
  parameter int LANES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_ready,
  input logic               done,
  input logic               done_timeout,
  input logic [AW-1:0]      fl_addr,
  input logic [LANES-1:0]   fl_ce_n,
  input logic [LANES-1:0]   fl_we_n,
  input logic               fl_oe_n,
  input logic [8*LANES-1:0] fl_dq_o,
  input logic               fl_dq_oe
);

  logic [15:0] we_run;

  always_ff @(posedge clk) begin
    if (!rst_n) we_run <= '0;
    else if (fl_we_n == '1) we_run <= '0;
    else we_run <= we_run + 1'b1;
  end

  p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (fl_ce_n == '1 && fl_we_n == '1 && fl_oe_n && !fl_dq_oe));

  p_we_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_we_n == '1 && $past(fl_we_n) != '1) |-> (we_run == 16'(WPUL)));

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_ce_n != '1 && $past(fl_ce_n) != '1) |-> $stable(fl_addr));

  p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_dq_oe && $past(fl_dq_oe)) |-> $stable(fl_dq_o));

  p_turnaround_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_oe_n) |-> !$past(fl_dq_oe));

  p_no_contend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |-> !fl_dq_oe);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_timeout_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_timeout |-> done);

  p_we_qualified_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_we_n != '1) |-> (((~fl_we_n & fl_ce_n) == '0) && fl_oe_n));

endmodule

bind pflash_host_ctrl pflash_host_ctrl_chk #(
  .WPUL(WPUL_C), .AW(AW), .LANES(LANES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done),
  .done_timeout(done_timeout), .fl_addr(fl_addr), .fl_ce_n(fl_ce_n),
  .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n), .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe)
);

// File: tb/pflash_host_ctrl_tb_top.sv
module pflash_host_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_poll = 1'b0;
  logic [3:0]  req_lanes = '0;
  logic [16:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [19:0] poll_limit = 20'd1000;
  logic        req_ready, done, done_timeout, fl_oe_n, fl_dq_oe;
  logic [31:0] done_rdata, fl_dq_o, fl_dq_i;
  logic [16:0] fl_addr;
  logic [3:0]  fl_ce_n, fl_we_n;

  always #10 clk = ~clk;

  pflash_host_ctrl #(.CLK_NS(20)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_poll(req_poll), .req_lanes(req_lanes),
    .req_addr(req_addr), .req_wdata(req_wdata), .poll_limit(poll_limit),
    .done(done), .done_rdata(done_rdata), .done_timeout(done_timeout),
    .fl_addr(fl_addr), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n),
    .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe), .fl_dq_i(fl_dq_i)
  );

  int vec = 0, bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // flash model, all state owned by one process
  logic [7:0] mem [4][16] = '{default: 8'h00};
  int   tbusy [4] = '{default: 0};
  logic tbit [4] = '{default: 1'b0};
  int   arm_seq = 0, arm_seen = 0, arm_lane = 0, arm_n = 0;
  logic arm_bit = 1'b0;
  int   we_rise [4] = '{default: 0};
  int   oe_fall = 0, we_run = 0, last_we_run = 0, oe_run = 0, last_oe_run = 0;
  int   viol_hold = 0, viol_bus = 0, viol_we = 0;
  logic [3:0]  ce_p = '1, we_p = '1;
  logic        oe_p = 1'b1, dqoe_p = 1'b0;
  logic [16:0] addr_p = '0;
  logic [31:0] dq_p = '0;

  always_comb begin
    for (int l = 0; l < 4; l++) begin
      logic [7:0] b;
      b = mem[l][fl_addr[3:0]];
      if (tbusy[l] > 0) b[6] = tbit[l];
      fl_dq_i[8*l +: 8] = (!fl_ce_n[l] && !fl_oe_n) ? b : 8'hEE;
    end
  end

  always @(negedge clk) begin
    for (int l = 0; l < 4; l++) begin
      if (!we_p[l] && fl_we_n[l]) begin
        mem[l][fl_addr[3:0]] <= fl_dq_o[8*l +: 8];
        we_rise[l] = we_rise[l] + 1;
      end
      if (!oe_p && fl_oe_n && !ce_p[l] && tbusy[l] > 0) begin
        tbit[l]  <= ~tbit[l];
        tbusy[l] <= tbusy[l] - 1;
      end
    end
    if (arm_seq != arm_seen) begin
      tbusy[arm_lane] <= arm_n;
      tbit[arm_lane]  <= arm_bit;
      arm_seen = arm_seq;
    end
    if (fl_we_n != '1) we_run++;
    else if (we_run != 0) begin last_we_run = we_run; we_run = 0; end
    if (!fl_oe_n) oe_run++;
    else if (oe_run != 0) begin last_oe_run = oe_run; oe_run = 0; end
    if (oe_p && !fl_oe_n) begin
      oe_fall++;
      if (dqoe_p) viol_bus++;
    end
    if (!fl_oe_n && fl_dq_oe) viol_bus++;
    if (fl_ce_n != '1 && ce_p != '1 && fl_addr != addr_p) viol_hold++;
    if (fl_dq_oe && dqoe_p && fl_dq_o != dq_p) viol_hold++;
    if ((~fl_we_n & fl_ce_n) != '0) viol_we++;
    if (fl_we_n != '1 && !fl_oe_n) viol_we++;
    ce_p = fl_ce_n; we_p = fl_we_n; oe_p = fl_oe_n; dqoe_p = fl_dq_oe;
    addr_p = fl_addr; dq_p = fl_dq_o;
  end

  int lat;
  logic [31:0] rd;
  bit to;

  task automatic run(input bit w, input bit p, input logic [3:0] ln,
                     input logic [16:0] ad, input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_poll = p;
    req_lanes = ln; req_addr = ad; req_wdata = wd;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (lat == 1) begin
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R7", "ready low while busy", req_ready, 0);
      end
    end while (!done && lat < 3000);
    lat = lat - 1;
    rd = done_rdata;
    to = done_timeout;
    @(negedge clk);
    chk(done == 1'b0, "R7", "done lasts one cycle", done, 0);
  endtask

  function automatic logic [31:0] lanemask(input logic [3:0] m);
    return {{8{m[3]}}, {8{m[2]}}, {8{m[1]}}, {8{m[0]}}};
  endfunction

  function automatic int poll_reads(input int busy, input bit t0, input bit mb);
    bit prev, cur;
    prev = (busy >= 1) ? t0 : mb;
    for (int i = 2; i < 200; i++) begin
      cur = (i <= busy) ? (t0 ^ bit'((i - 1) & 1)) : mb;
      if (cur == prev) return i;
      prev = cur;
    end
    return 200;
  endfunction

  logic [31:0] expm [16];
  int wr0 [4];
  int ofall0, n_exp;

  initial begin
    repeat (3) @(negedge clk);
    chk(fl_ce_n == '1 && fl_we_n == '1 && fl_oe_n && !fl_dq_oe, "R1",
        "pins idle in reset", {fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe}, 10'h3FE);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !done && fl_ce_n == '1 && fl_oe_n, "R1", "idle after reset",
        {req_ready, done}, 2'b10);

    for (int a = 0; a < 16; a++) begin
      expm[a] = {8'(a * 7 + 1), 8'(a * 5 + 66), 8'(a * 3 + 3), 8'(a * 9 + 64)};
      run(1'b1, 1'b0, 4'hF, 17'(a), expm[a]);
      chk(lat == 4, "R4", "write done latency", lat, 4);
      chk(last_we_run == 2, "R2", "write pulse width", last_we_run, 2);
    end

    for (int m = 0; m < 16; m++) begin
      logic [31:0] d;
      d = 32'hC3A5_5A3C ^ {4{8'(m * 17)}};
      for (int l = 0; l < 4; l++) wr0[l] = we_rise[l];
      run(1'b1, 1'b0, 4'(m), 17'(m), d);
      for (int l = 0; l < 4; l++)
        chk((we_rise[l] - wr0[l]) == int'(m[l]), "R2", "lane strobe count",
            we_rise[l] - wr0[l], m[l]);
      chk(lat == 4, "R4", "masked write latency", lat, 4);
      expm[m] = (expm[m] & ~lanemask(4'(m))) | (d & lanemask(4'(m)));
    end

    for (int a = 0; a < 16; a++) begin
      run(1'b0, 1'b0, 4'hF, 17'(a), 32'hFFFF_FFFF);
      chk(rd == expm[a], "R11", "read back after masked writes", rd, expm[a]);
      chk(lat == 5, "R5", "read done latency", lat, 5);
      chk(last_oe_run == 3, "R5", "output enable width", last_oe_run, 3);
    end

    for (int m = 0; m < 16; m++) begin
      run(1'b0, 1'b0, 4'(m), 17'(15 - m), '0);
      chk(rd == (expm[15 - m] & lanemask(4'(m))), "R5", "lane-masked read",
          rd, expm[15 - m] & lanemask(4'(m)));
    end

    for (int k = 0; k < 2; k++) begin
      int ad;
      ad = (k == 0) ? 5 : 9;
      arm_lane = 2; arm_n = 6; arm_bit = 1'b0; arm_seq++;
      @(negedge clk);
      poll_limit = 20'd1000;
      n_exp = poll_reads(6, 1'b0, expm[ad][22]);
      ofall0 = oe_fall;
      run(1'b1, 1'b1, 4'b0100, 17'(ad), '0);
      chk(to == 1'b0, "R8", "poll completes without timeout", to, 0);
      chk(oe_fall - ofall0 == n_exp, "R8", "poll read count", oe_fall - ofall0, n_exp);
      chk(lat == 5 * n_exp, "R8", "poll latency", lat, 5 * n_exp);
      chk(rd == (expm[ad] & 32'h00FF_0000), "R8", "poll final data", rd,
          expm[ad] & 32'h00FF_0000);
    end

    poll_limit = 20'd0;
    ofall0 = oe_fall;
    run(1'b0, 1'b1, 4'b0001, 17'd3, '0);
    chk(to == 1'b1, "R9", "zero budget times out", to, 1);
    chk(oe_fall - ofall0 == 1, "R9", "single read before timeout", oe_fall - ofall0, 1);

    arm_lane = 1; arm_n = 40; arm_bit = 1'b1; arm_seq++;
    @(negedge clk);
    poll_limit = 20'd23;
    ofall0 = oe_fall;
    run(1'b0, 1'b1, 4'b0010, 17'd7, '0);
    chk(to == 1'b1, "R9", "budget exhausted", to, 1);
    chk(oe_fall - ofall0 == 5, "R9", "reads until budget", oe_fall - ofall0, 5);
    chk(lat == 25, "R9", "timeout latency", lat, 25);

    chk(viol_hold == 0, "R3", "address/data changed inside strobe", viol_hold, 0);
    chk(viol_bus == 0, "R6", "bus turnaround violations", viol_bus, 0);
    chk(viol_we == 0, "R10", "unqualified write enable", viol_we, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

endmodule